// File: doc/BRIEF.md
# Alarm Status Word With Per-Bit Latching

This block watches the measurement results of a three-phase metering datapath and keeps a 32-bit alarm status word. Once per accumulation interval, marked by a one-cycle strobe, it compares the rms voltage, rms current, power factor and line-to-line voltage imbalance of each phase against programmable limits. It also compares the die temperature against an upper and a lower limit. Each comparison that trips drives its own status bit. Limits use the same units and scaling as the results they guard, and a limit programmed to zero turns its comparison off.

A 32-bit latch mask gives each status bit its own clearing policy. A bit whose mask bit is clear follows its condition at every interval update. A bit whose mask bit is set stays high once tripped, until the host writes the status word. A host write loads the word directly, so writing zero clears latched alarms. A separate command-complete pulse sets the top bit, which holds until the host writes it.

Top module: `alarm_status`

## Requirements
- R1: After reset the status word is all zero.
- R2: Over-limit alarms trip only when the value is strictly greater than its limit. Over-voltage uses bits 18/17/16 and over-current uses bits 9/8/7, for phases A/B/C. Imbalance uses bits 12/11/10 for A/B/C. Over-temperature uses bit 3, with the temperature and its limits taken as two's complement.
- R3: Under-limit alarms trip only when the value is strictly less than its limit. Under-voltage uses bits 15/14/13 and under-current uses bits 6/5/4, for A/B/C. Under-temperature uses bit 2 (signed).
- R4: The power-factor alarm on bits 22/21/20 (A/B/C) trips when the magnitude of the signed two's complement power factor is strictly less than the unsigned minimum.
- R5: A limit of zero disables its comparison, so the matching bit is never set by a result.
- R6: Limits are evaluated only in a cycle with `interval_done` high. With no strobe, no host write and no command pulse, the status word does not change.
- R7: On an interval update, a bit whose latch-mask bit is 0 takes the value of its condition.
- R8: On an interval update, a bit whose latch-mask bit is 1 is set if its condition is true and otherwise keeps its value.
- R9: A host write loads the status word from `host_wdata`. Bits 0, 1, 19 and 23 to 30 always read zero.
- R10: When a host write and an interval update fall in the same cycle, the write is applied first and the update second. A true condition therefore always leaves its bit set.
- R11: A `cmd_done` pulse sets bit 31, and this wins over a host write in the same cycle. Bit 31 is cleared only by a host write and is not touched by interval updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| interval_done | input | 1 | One-cycle end-of-accumulation strobe |
| v_rms | input | 3*MW | Rms voltage, phase A in bits MW-1:0, then B, then C |
| i_rms | input | 3*MW | Rms current, same phase packing |
| pf | input | 3*MW | Signed power factor per phase, same packing |
| v_imb | input | 3*MW | Voltage imbalance per phase, same packing |
| temp | input | MW | Signed die temperature |
| lim_v_hi | input | MW | Over-voltage limit |
| lim_v_lo | input | MW | Under-voltage limit |
| lim_i_hi | input | MW | Over-current limit |
| lim_i_lo | input | MW | Under-current limit |
| lim_t_hi | input | MW | Signed over-temperature limit |
| lim_t_lo | input | MW | Signed under-temperature limit |
| lim_imb | input | MW | Imbalance limit |
| lim_pf | input | MW | Minimum power-factor magnitude |
| latch_mask | input | 32 | Per-bit latch select |
| host_we | input | 1 | Host write strobe for the status word |
| host_wdata | input | 32 | Host write data |
| cmd_done | input | 1 | Command-complete pulse |
| status | output | 32 | Alarm status word |

## Verification
The assertions check several rules on every cycle. The word holds its value when no event occurs. An update leaves every tripped condition set. Unlatched alarm bits equal their condition after an update. A command pulse always shows up in bit 31. A zero limit never produces a comparator hit. Only the bench's scenarios can show the rest: the exact boundary of each limit, signed temperature and power-factor handling, and the mapping of each condition to its bit position. They also cover the full sequence of a latched bit set, held across clean intervals and cleared by a write, and the outcome of a write that lands together with an update.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int SW = 32;
  localparam int NPH = 3;

  // bit positions per phase index (0 = A, 1 = B, 2 = C)
  function automatic int pos_ov(input int p);  return 18 - p; endfunction
  function automatic int pos_uv(input int p);  return 15 - p; endfunction
  function automatic int pos_imb(input int p); return 12 - p; endfunction
  function automatic int pos_oc(input int p);  return 9 - p;  endfunction
  function automatic int pos_uc(input int p);  return 6 - p;  endfunction
  function automatic int pos_pf(input int p);  return 22 - p; endfunction
  localparam int POS_OT   = 3;
  localparam int POS_UT   = 2;
  localparam int POS_DONE = 31;

  localparam logic [SW-1:0] ALARM_MASK = 32'h0077_FFFC;
  localparam logic [SW-1:0] DONE_MASK  = 32'h8000_0000;
  localparam logic [SW-1:0] VALID_MASK = ALARM_MASK | DONE_MASK;

  // next-state rule: write first, then interval update, then done pulse
  function automatic logic [SW-1:0] next_word(
    input logic [SW-1:0] cur,
    input logic [SW-1:0] cond,
    input logic [SW-1:0] latch,
    input logic          we,
    input logic [SW-1:0] wdata,
    input logic          upd,
    input logic          done
  );
    logic [SW-1:0] w;
    w = we ? (wdata & VALID_MASK) : cur;
    if (upd)
      w = ((cond | (latch & w)) & ALARM_MASK) | (w & DONE_MASK);
    if (done)
      w = w | DONE_MASK;
    return w;
  endfunction
endpackage

// File: rtl/alarm_phase_cmp.sv
module alarm_phase_cmp #(
  parameter int MW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [MW-1:0] v,
  input  logic [MW-1:0] i,
  input  logic [MW-1:0] pf,
  input  logic [MW-1:0] imb,
  input  logic [MW-1:0] lim_v_hi,
  input  logic [MW-1:0] lim_v_lo,
  input  logic [MW-1:0] lim_i_hi,
  input  logic [MW-1:0] lim_i_lo,
  input  logic [MW-1:0] lim_imb,
  input  logic [MW-1:0] lim_pf,
  output logic          ov_hit,
  output logic          uv_hit,
  output logic          oc_hit,
  output logic          uc_hit,
  output logic          imb_hit,
  output logic          pf_hit
);
  function automatic logic above(input logic [MW-1:0] val, input logic [MW-1:0] lim);
    return (lim != '0) && (val > lim);
  endfunction

  function automatic logic below(input logic [MW-1:0] val, input logic [MW-1:0] lim);
    return (lim != '0) && (val < lim);
  endfunction

  function automatic logic [MW:0] magnitude(input logic [MW-1:0] x);
    logic [MW:0] xe;
    xe = {x[MW-1], x};
    return xe[MW] ? (~xe + 1'b1) : xe;
  endfunction

  logic [MW:0] pf_mag;

  always_comb begin
    pf_mag  = magnitude(pf);
    ov_hit  = above(v, lim_v_hi);
    uv_hit  = below(v, lim_v_lo);
    oc_hit  = above(i, lim_i_hi);
    uc_hit  = below(i, lim_i_lo);
    imb_hit = above(imb, lim_imb);
    pf_hit  = (lim_pf != '0) && (pf_mag < {1'b0, lim_pf});
  end

  AST_ZERO_VHI_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_v_hi == '0) |-> !ov_hit); // R5
  AST_ZERO_ILO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_i_lo == '0) |-> !uc_hit); // R5
  AST_ZERO_PF_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_pf == '0) |-> !pf_hit); // R5
  AST_V_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_v_lo <= lim_v_hi) |-> !(ov_hit && uv_hit)); // R2
endmodule

// File: rtl/alarm_temp_cmp.sv
module alarm_temp_cmp #(
  parameter int MW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [MW-1:0] temp,
  input  logic [MW-1:0] lim_t_hi,
  input  logic [MW-1:0] lim_t_lo,
  output logic          ot_hit,
  output logic          ut_hit
);
  always_comb begin
    ot_hit = (lim_t_hi != '0) && ($signed(temp) > $signed(lim_t_hi));
    ut_hit = (lim_t_lo != '0) && ($signed(temp) < $signed(lim_t_lo));
  end

  AST_ZERO_T_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ((lim_t_hi == '0) |-> !ot_hit) and ((lim_t_lo == '0) |-> !ut_hit)); // R5
endmodule

// File: rtl/alarm_status_reg.sv
module alarm_status_reg
  import alarm_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd,
  input  logic [SW-1:0] cond,
  input  logic [SW-1:0] latch,
  input  logic          we,
  input  logic [SW-1:0] wdata,
  input  logic          done,
  output logic [SW-1:0] word
);
  logic [SW-1:0] word_nx;

  always_comb word_nx = next_word(word, cond, latch, we, wdata, upd, done);

  always_ff @(posedge clk) begin
    if (!rst_n) word <= '0;
    else        word <= word_nx;
  end

  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd && !we && !done) |=> $stable(word)); // R6
  AST_COND_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> ((word & $past(cond)) == $past(cond))); // R10
  AST_UNLATCHED_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> (((word ^ $past(cond)) & ~$past(latch) & ALARM_MASK) == '0)); // R7
  AST_DONE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> word[POS_DONE]); // R11
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (word & ~VALID_MASK) == '0); // R9
endmodule

// File: rtl/alarm_status.sv
module alarm_status
  import alarm_pkg::*;
#(
  parameter int MW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            interval_done,
  input  logic [3*MW-1:0] v_rms,
  input  logic [3*MW-1:0] i_rms,
  input  logic [3*MW-1:0] pf,
  input  logic [3*MW-1:0] v_imb,
  input  logic [MW-1:0]   temp,
  input  logic [MW-1:0]   lim_v_hi,
  input  logic [MW-1:0]   lim_v_lo,
  input  logic [MW-1:0]   lim_i_hi,
  input  logic [MW-1:0]   lim_i_lo,
  input  logic [MW-1:0]   lim_t_hi,
  input  logic [MW-1:0]   lim_t_lo,
  input  logic [MW-1:0]   lim_imb,
  input  logic [MW-1:0]   lim_pf,
  input  logic [31:0]     latch_mask,
  input  logic            host_we,
  input  logic [31:0]     host_wdata,
  input  logic            cmd_done,
  output logic [31:0]     status
);
  logic [NPH-1:0] ov_hit, uv_hit, oc_hit, uc_hit, imb_hit, pf_hit;
  logic           ot_hit, ut_hit;
  logic [SW-1:0]  cond;

  for (genvar p = 0; p < NPH; p++) begin : g_phase
    alarm_phase_cmp #(.MW(MW)) u_cmp (
      .clk      (clk),
      .rst_n    (rst_n),
      .v        (v_rms[p*MW +: MW]),
      .i        (i_rms[p*MW +: MW]),
      .pf       (pf[p*MW +: MW]),
      .imb      (v_imb[p*MW +: MW]),
      .lim_v_hi (lim_v_hi),
      .lim_v_lo (lim_v_lo),
      .lim_i_hi (lim_i_hi),
      .lim_i_lo (lim_i_lo),
      .lim_imb  (lim_imb),
      .lim_pf   (lim_pf),
      .ov_hit   (ov_hit[p]),
      .uv_hit   (uv_hit[p]),
      .oc_hit   (oc_hit[p]),
      .uc_hit   (uc_hit[p]),
      .imb_hit  (imb_hit[p]),
      .pf_hit   (pf_hit[p])
    );
  end

  alarm_temp_cmp #(.MW(MW)) u_temp (
    .clk      (clk),
    .rst_n    (rst_n),
    .temp     (temp),
    .lim_t_hi (lim_t_hi),
    .lim_t_lo (lim_t_lo),
    .ot_hit   (ot_hit),
    .ut_hit   (ut_hit)
  );

  always_comb begin
    cond = '0;
    for (int p = 0; p < NPH; p++) begin
      cond[pos_ov(p)]  = ov_hit[p];
      cond[pos_uv(p)]  = uv_hit[p];
      cond[pos_oc(p)]  = oc_hit[p];
      cond[pos_uc(p)]  = uc_hit[p];
      cond[pos_imb(p)] = imb_hit[p];
      cond[pos_pf(p)]  = pf_hit[p];
    end
    cond[POS_OT] = ot_hit;
    cond[POS_UT] = ut_hit;
  end

  alarm_status_reg u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .upd   (interval_done),
    .cond  (cond),
    .latch (latch_mask),
    .we    (host_we),
    .wdata (host_wdata),
    .done  (cmd_done),
    .word  (status)
  );

  AST_LATCHED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (interval_done && !host_we) |=>
      (((status & $past(status) & $past(latch_mask) & ALARM_MASK))
        == ($past(status) & $past(latch_mask) & ALARM_MASK))); // R8
endmodule

// File: tb/alarm_status_test.sv
module alarm_status_test;
  localparam int MW = 16;

  typedef struct packed {
    logic [15:0] va, vb, vc, ia, ib, ic, pa, pb, pc, tp, ma, mb, mc;
    logic [31:0] stk;
    logic        we;
    logic [31:0] wd;
  } row_t;

  localparam int NROW = 13;
  // nominal: v 220, i 50, pf 900, temp 25, imbalance 5
  localparam row_t TBL [NROW] = '{
    '{16'd220,16'd220,16'd220,16'd50,16'd50,16'd50,16'd900,16'd900,16'd900,16'd25,16'd5,16'd5,16'd5,32'h0,1'b0,32'h0},
    '{16'd241,16'd220,16'd220,16'd50,16'd50,16'd50,16'd900,16'd900,16'd900,16'd25,16'd5,16'd5,16'd5,32'h0,1'b0,32'h0},
    '{16'd240,16'd220,16'd199,16'd50,16'd50,16'd50,16'd900,16'd900,16'd900,16'd25,16'd5,16'd5,16'd5,32'h0,1'b0,32'h0},
    '{16'd220,16'd200,16'd220,16'd101,16'd50,16'd9,16'd900,16'd900,16'd900,16'd25,16'd5,16'd5,16'd5,32'h0,1'b0,32'h0},
    '{16'd220,16'd220,16'd220,16'd50,16'd100,16'd10,16'd900,16'd900,16'd900,16'd81,16'd5,16'd5,16'd5,32'h0,1'b0,32'h0},
    '{16'd220,16'd220,16'd220,16'd50,16'd50,16'd50,16'd900,16'd900,16'd900,16'hFFF5,16'd5,16'd5,16'd5,32'h0,1'b0,32'h0},
    '{16'd220,16'd220,16'd220,16'd50,16'd50,16'd50,16'hFED4,16'd900,16'd900,16'hFFF6,16'd5,16'd21,16'd5,32'h0,1'b0,32'h0},
    '{16'd220,16'd220,16'd220,16'd50,16'd50,16'd50,16'hFD44,16'd900,16'd499,16'd80,16'd5,16'd5,16'd20,32'h0,1'b0,32'h0},
    '{16'd250,16'd220,16'd220,16'd50,16'd50,16'd50,16'd900,16'd900,16'd900,16'd25,16'd5,16'd5,16'd5,32'hFFFF_FFFF,1'b0,32'h0},
    '{16'd220,16'd220,16'd220,16'd50,16'd50,16'd50,16'd900,16'd900,16'd900,16'd25,16'd5,16'd5,16'd5,32'hFFFF_FFFF,1'b0,32'h0},
    '{16'd220,16'd220,16'd220,16'd50,16'd50,16'd50,16'd900,16'd900,16'd900,16'd25,16'd5,16'd5,16'd5,32'hFFFF_FFFF,1'b1,32'h0},
    '{16'd241,16'd220,16'd220,16'd50,16'd50,16'd50,16'd900,16'd900,16'd900,16'd25,16'd5,16'd5,16'd5,32'h0,1'b1,32'h0000_4000},
    '{16'd220,16'd220,16'd220,16'd50,16'd50,16'd50,16'd900,16'd900,16'd900,16'd25,16'd5,16'd5,16'd5,32'h0000_0008,1'b1,32'h0000_0008}
  };

  localparam int OVB [3] = '{18, 17, 16};
  localparam int UVB [3] = '{15, 14, 13};
  localparam int IMB [3] = '{12, 11, 10};
  localparam int OCB [3] = '{9, 8, 7};
  localparam int UCB [3] = '{6, 5, 4};
  localparam int PFB [3] = '{22, 21, 20};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic interval_done = 1'b0;
  logic [3*MW-1:0] v_rms = '0, i_rms = '0, pf = '0, v_imb = '0;
  logic [MW-1:0] temp = '0;
  logic [MW-1:0] lim_v_hi = 16'd240, lim_v_lo = 16'd200, lim_i_hi = 16'd100, lim_i_lo = 16'd10;
  logic [MW-1:0] lim_t_hi = 16'd80, lim_t_lo = 16'hFFF6, lim_imb = 16'd20, lim_pf = 16'd500;
  logic [31:0] latch_mask = '0;
  logic host_we = 1'b0;
  logic [31:0] host_wdata = '0;
  logic cmd_done = 1'b0;
  logic [31:0] status;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] model = '0;

  always #5 clk = ~clk;

  alarm_status #(.MW(MW)) uut (
    .clk(clk), .rst_n(rst_n), .interval_done(interval_done),
    .v_rms(v_rms), .i_rms(i_rms), .pf(pf), .v_imb(v_imb), .temp(temp),
    .lim_v_hi(lim_v_hi), .lim_v_lo(lim_v_lo), .lim_i_hi(lim_i_hi), .lim_i_lo(lim_i_lo),
    .lim_t_hi(lim_t_hi), .lim_t_lo(lim_t_lo), .lim_imb(lim_imb), .lim_pf(lim_pf),
    .latch_mask(latch_mask), .host_we(host_we), .host_wdata(host_wdata),
    .cmd_done(cmd_done), .status(status)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: status=%08h expected=%08h", req, act, exp);
    end
  endtask

  // expected conditions restated from the requirements, in integer arithmetic
  function automatic logic [31:0] conds(input row_t r);
    logic [31:0] c;
    int vv [3], ii [3], pp [3], mm [3];
    int t;
    c = '0;
    vv = '{int'(r.va), int'(r.vb), int'(r.vc)};
    ii = '{int'(r.ia), int'(r.ib), int'(r.ic)};
    pp = '{int'($signed(r.pa)), int'($signed(r.pb)), int'($signed(r.pc))};
    mm = '{int'(r.ma), int'(r.mb), int'(r.mc)};
    t = int'($signed(r.tp));
    for (int k = 0; k < 3; k++) begin
      if (lim_v_hi != 0 && vv[k] > int'(lim_v_hi)) c[OVB[k]] = 1'b1;
      if (lim_v_lo != 0 && vv[k] < int'(lim_v_lo)) c[UVB[k]] = 1'b1;
      if (lim_i_hi != 0 && ii[k] > int'(lim_i_hi)) c[OCB[k]] = 1'b1;
      if (lim_i_lo != 0 && ii[k] < int'(lim_i_lo)) c[UCB[k]] = 1'b1;
      if (lim_imb != 0 && mm[k] > int'(lim_imb)) c[IMB[k]] = 1'b1;
      if (lim_pf != 0 && (pp[k] < 0 ? -pp[k] : pp[k]) < int'(lim_pf)) c[PFB[k]] = 1'b1;
    end
    if (lim_t_hi != 0 && t > int'($signed(lim_t_hi))) c[3] = 1'b1;
    if (lim_t_lo != 0 && t < int'($signed(lim_t_lo))) c[2] = 1'b1;
    return c;
  endfunction

  function automatic logic [31:0] legal(input logic [31:0] d);
    logic [31:0] o;
    o = d;
    for (int b = 0; b < 32; b++)
      if (b < 2 || b == 19 || (b >= 23 && b <= 30)) o[b] = 1'b0;
    return o;
  endfunction

  task automatic drive_row(input row_t r, input logic strobe);
    @(negedge clk);
    v_rms = {r.vc, r.vb, r.va};
    i_rms = {r.ic, r.ib, r.ia};
    pf    = {r.pc, r.pb, r.pa};
    v_imb = {r.mc, r.mb, r.ma};
    temp  = r.tp;
    latch_mask = r.stk;
    host_we = r.we;
    host_wdata = r.wd;
    interval_done = strobe;
    @(negedge clk);
    interval_done = 1'b0;
    host_we = 1'b0;
  endtask

  function automatic logic [31:0] step(input logic [31:0] cur, input row_t r);
    logic [31:0] base, c, o;
    base = r.we ? legal(r.wd) : cur;
    c = conds(r);
    o = '0;
    for (int b = 0; b < 31; b++)
      o[b] = c[b] | (r.stk[b] & base[b]);
    o[31] = base[31];
    return legal(o);
  endfunction

  row_t nom;

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: status=%08h expected=finished", status);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    nom = TBL[0];
    repeat (3) @(negedge clk);
    check("R1 reset", status, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", status, 32'h0);

    // table walk: R2 R3 R4 R7 R8 R9 R10
    for (int n = 0; n < NROW; n++) begin
      model = step(model, TBL[n]);
      drive_row(TBL[n], 1'b1);
      check($sformatf("R2/R3/R4/R7/R8/R10 row %0d", n), status, model);
    end

    // R5: zero limit disables over-voltage even for an extreme value
    lim_v_hi = '0;
    nom.va = 16'd60000;
    model = step(model, nom);
    drive_row(nom, 1'b1);
    check("R5 zero limit", status & 32'h0004_0000, 32'h0);
    lim_v_hi = 16'd240;

    // R6: inputs far out of range, no strobe: status must hold
    nom.va = 16'd300;
    nom.ic = 16'd0;
    drive_row(nom, 1'b0);
    repeat (3) @(negedge clk);
    check("R6 no strobe hold", status, model);
    nom = TBL[0];

    // R9: write all ones without update, reserved bits read zero
    nom.we = 1'b1;
    nom.wd = 32'hFFFF_FFFF;
    drive_row(nom, 1'b0);
    model = 32'h8077_FFFC;
    check("R9 write masked", status, model);

    // R11: interval update with no latch clears alarms but not bit 31
    nom.we = 1'b0;
    model = step(model, nom);
    drive_row(nom, 1'b1);
    check("R11 update keeps bit31", status, 32'h8000_0000);

    // R9: write zero clears bit 31
    nom.we = 1'b1;
    nom.wd = 32'h0;
    drive_row(nom, 1'b0);
    check("R9 write zero", status, 32'h0);

    // R11: done pulse sets bit 31
    @(negedge clk);
    cmd_done = 1'b1;
    @(negedge clk);
    cmd_done = 1'b0;
    check("R11 done sets", status, 32'h8000_0000);

    // R11: done and write of zero in the same cycle: done wins
    host_we = 1'b1;
    host_wdata = 32'h0;
    cmd_done = 1'b1;
    @(negedge clk);
    host_we = 1'b0;
    cmd_done = 1'b0;
    check("R11 done beats write", status, 32'h8000_0000);

    // R10: write zero with a true latched-off condition in the same cycle
    nom = TBL[0];
    nom.ib = 16'd5;
    nom.we = 1'b1;
    nom.wd = 32'h0;
    drive_row(nom, 1'b1);
    check("R10 write plus update", status, 32'h0000_0020);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule